// File: doc/BRIEF.md
# I2C Control Register Slave

This block is a write-mostly I2C slave that fills a bank of ten 8-bit control registers and answers reads with one status byte. SCL and SDA are oversampled by the system clock through two-flop synchronisers. START and STOP are found on the synchronised lines, and the slave pulls SDA low through an open-drain style enable (`sda_pull`). The seven-bit device address is a fixed six-bit prefix with the `addr_sel` pin as its lowest bit.

A write carries the address byte (R/W bit = 0), a subaddress byte and any number of data bytes. The subaddress gives a 4-bit register pointer and an auto-increment flag. With the flag set, the pointer steps modulo 16 after every data byte, and bytes aimed at pointer values 10 to 15 are acknowledged but dropped. With the flag clear, every data byte rewrites the same register. A read (R/W bit = 1) streams the status byte: after each master ACK the status is sampled again, and a NACK ends the read. A START is honoured only when the bus has been closed by a STOP. A START inside an open transfer is not seen, and its clocks go on counting as data bits.

The controller is one state machine. Its states are IDLE (bus free, waiting for START), ADDR (shift in the address byte), ADDR_ACK (drive the address acknowledge), SUB (shift in the subaddress), SUB_ACK, DATA (shift in a data byte), DATA_ACK, TX (shift out the status byte), TX_ACK (sample the master's acknowledge) and IGNORE (wait for STOP). Its transitions are: START while free, from any state, to ADDR. STOP, from any state, to IDLE. ADDR to ADDR_ACK on an address match at the ninth falling SCL edge, or to IGNORE on a mismatch. ADDR_ACK to TX for a read or to SUB for a write. SUB to SUB_ACK, then to DATA. DATA to DATA_ACK, then back to DATA. TX to TX_ACK after eight bits. TX_ACK to TX on ACK or to IGNORE on NACK.

Top module: `i2c_ctrl_slave`

## Requirements
- R1: A STOP (SDA rising while SCL is high) returns the slave to idle and marks the bus free; a START (SDA falling while SCL is high) on a free bus begins a new transfer.
- R2: The address byte is compared MSB first against {6'b100010, addr_sel}; its LSB is the R/W bit. On a match the slave pulls SDA low in the ninth clock. On a mismatch it gives no acknowledge and ignores the bus until STOP.
- R3: In the subaddress byte, bits 3:0 are the register pointer, bit 4 enables auto-increment and bits 7:5 have no effect; the byte is acknowledged.
- R4: Each data byte is received MSB first, acknowledged, and written to the register at the pointer; register i appears at ctrl_regs[8*i+7 : 8*i].
- R5: With auto-increment set, the pointer advances modulo 16 after every data byte; bytes at pointers 10 to 15 are acknowledged but change no register, and the pointer reaches 0 only after 15.
- R6: With auto-increment clear, all data bytes of a transfer rewrite the same register, and the last one remains.
- R7: A START that arrives while a transfer is open (no STOP since the last accepted START) is not recognised; its SCL pulse and the following bits are shifted in as ordinary data.
- R8: A read returns MSB first the status byte {4'b0000, stat_stereo, stat_soft_mute, stat_zc_mute, stat_pause_n}.
- R9: During a read the status byte is sampled again at the end of each master ACK and sent again; after a master NACK the slave releases SDA and ignores the bus until STOP.
- R10: Reset clears all ten registers to 0x00, releases SDA and marks the bus free.
- R11: sda_pull changes only while SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 8 times the bit rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_in | input | 1 | Serial clock line as seen on the bus |
| sda_in | input | 1 | Serial data line as seen on the bus |
| addr_sel | input | 1 | Lowest bit of the device address |
| stat_pause_n | input | 1 | Pause status, low when a pause is detected |
| stat_zc_mute | input | 1 | Zero-cross mute engaged |
| stat_soft_mute | input | 1 | Soft mute engaged |
| stat_stereo | input | 1 | Stereo signal detected |
| sda_pull | output | 1 | High to pull SDA low (open-drain enable) |
| ctrl_regs | output | 80 | Ten control registers, register i in bits 8*i+7 : 8*i |

## Verification
On every cycle the assertions check that SDA is only pulled while SCL is low and that SDA stays released while the bus is free. They also check that a STOP always lands in idle, that the register bank moves only after a write strobe, and that no write strobe ever names a pointer of 10 or more. The scenarios are needed for the rest: address matching on the select pin, the modulo-16 walk through the dropped indices back to register 0, the streaming of bytes into one register, the START swallowed as data bits, and the status byte being sampled again between ACKed reads.

// File: rtl/i2c_ctrl_pkg.sv
package i2c_ctrl_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_ADDR,
        ST_ADDR_ACK,
        ST_SUB,
        ST_SUB_ACK,
        ST_DATA,
        ST_DATA_ACK,
        ST_TX,
        ST_TX_ACK,
        ST_IGNORE
    } cs_state_t;

    localparam int unsigned BYTE_W = 8;

endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_in,
    input  logic sda_in,
    output logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);

    logic [STAGES-1:0] scl_pipe;
    logic [STAGES-1:0] sda_pipe;
    logic              scl_q;
    logic              sda_q;
    logic              scl_s;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_pipe <= '1;
            sda_pipe <= '1;
            scl_q    <= 1'b1;
            sda_q    <= 1'b1;
        end else begin
            scl_pipe <= {scl_pipe[STAGES-2:0], scl_in};
            sda_pipe <= {sda_pipe[STAGES-2:0], sda_in};
            scl_q    <= scl_pipe[STAGES-1];
            sda_q    <= sda_pipe[STAGES-1];
        end
    end

    assign scl_s     = scl_pipe[STAGES-1];
    assign sda_s     = sda_pipe[STAGES-1];
    assign scl_rise  = scl_s & ~scl_q;
    assign scl_fall  = ~scl_s & scl_q;
    assign start_det = scl_s & scl_q & ~sda_s & sda_q;
    assign stop_det  = scl_s & scl_q & sda_s & ~sda_q;

endmodule

// File: rtl/i2c_reg_file.sv
module i2c_reg_file #(
    parameter int unsigned NREG  = 10,
    parameter int unsigned W     = 8,
    parameter int unsigned IDX_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [W-1:0]      wr_data,
    output logic [NREG*W-1:0] regs_flat
);

    for (genvar g = 0; g < NREG; g++) begin : g_reg
        logic [W-1:0] r;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                r <= '0;
            end else if (wr_en && wr_idx == IDX_W'(g)) begin
                r <= wr_data;
            end
        end
        assign regs_flat[g*W +: W] = r;
    end

endmodule

// File: rtl/i2c_ctrl_slave.sv
module i2c_ctrl_slave
    import i2c_ctrl_pkg::*;
#(
    parameter int unsigned NREG        = 10,
    parameter int unsigned PTR_W       = 4,
    parameter logic [5:0]  DEV_PREFIX  = 6'b100010,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   scl_in,
    input  logic                   sda_in,
    input  logic                   addr_sel,
    input  logic                   stat_pause_n,
    input  logic                   stat_zc_mute,
    input  logic                   stat_soft_mute,
    input  logic                   stat_stereo,
    output logic                   sda_pull,
    output logic [NREG*BYTE_W-1:0] ctrl_regs
);

    localparam logic [3:0]       BITS_FULL = 4'd8;
    localparam logic [3:0]       TX_LAST   = 4'd7;
    localparam logic [PTR_W-1:0] PTR_LIMIT = PTR_W'(NREG);

    cs_state_t         state, state_nx;
    logic              sda_s, scl_rise, scl_fall, start_det, stop_det;
    logic [7:0]        shreg;
    logic [7:0]        txsh;
    logic [3:0]        bitcnt;
    logic [PTR_W-1:0]  ptr;
    logic              inc_en;
    logic              rd_mode;
    logic              mack;
    logic              bus_free;
    logic              wr_en;
    logic [PTR_W-1:0]  wr_idx;
    logic [7:0]        wr_data;
    logic              byte_done;
    logic              addr_hit;
    logic [7:0]        status_byte;

    i2c_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .scl_in   (scl_in),
        .sda_in   (sda_in),
        .sda_s    (sda_s),
        .scl_rise (scl_rise),
        .scl_fall (scl_fall),
        .start_det(start_det),
        .stop_det (stop_det)
    );

    i2c_reg_file #(.NREG(NREG), .W(BYTE_W), .IDX_W(PTR_W)) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .wr_idx   (wr_idx),
        .wr_data  (wr_data),
        .regs_flat(ctrl_regs)
    );

    assign byte_done   = (bitcnt == BITS_FULL);
    assign addr_hit    = (shreg[7:1] == {DEV_PREFIX, addr_sel});
    assign status_byte = {4'b0000, stat_stereo, stat_soft_mute, stat_zc_mute, stat_pause_n};

    // next-state logic
    always_comb begin
        state_nx = state;
        if (stop_det) begin
            state_nx = ST_IDLE;
        end else if (start_det && bus_free) begin
            state_nx = ST_ADDR;
        end else begin
            unique case (state)
                ST_IDLE:     state_nx = ST_IDLE;
                ST_ADDR:     if (scl_fall && byte_done) state_nx = addr_hit ? ST_ADDR_ACK : ST_IGNORE;
                ST_ADDR_ACK: if (scl_fall) state_nx = rd_mode ? ST_TX : ST_SUB;
                ST_SUB:      if (scl_fall && byte_done) state_nx = ST_SUB_ACK;
                ST_SUB_ACK:  if (scl_fall) state_nx = ST_DATA;
                ST_DATA:     if (scl_fall && byte_done) state_nx = ST_DATA_ACK;
                ST_DATA_ACK: if (scl_fall) state_nx = ST_DATA;
                ST_TX:       if (scl_fall && bitcnt == TX_LAST) state_nx = ST_TX_ACK;
                ST_TX_ACK:   if (scl_fall) state_nx = mack ? ST_TX : ST_IGNORE;
                ST_IGNORE:   state_nx = ST_IGNORE;
                default:     state_nx = ST_IDLE;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    // datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            shreg    <= '0;
            txsh     <= '0;
            bitcnt   <= '0;
            ptr      <= '0;
            inc_en   <= 1'b0;
            rd_mode  <= 1'b0;
            mack     <= 1'b0;
            bus_free <= 1'b1;
            wr_en    <= 1'b0;
            wr_idx   <= '0;
            wr_data  <= '0;
        end else begin
            wr_en <= 1'b0;
            if (stop_det) begin
                bus_free <= 1'b1;
                bitcnt   <= '0;
            end else if (start_det && bus_free) begin
                bus_free <= 1'b0;
                bitcnt   <= '0;
            end else begin
                unique case (state)
                    ST_ADDR, ST_SUB, ST_DATA: begin
                        if (scl_rise && !byte_done) begin
                            shreg  <= {shreg[6:0], sda_s};
                            bitcnt <= bitcnt + 4'd1;
                        end
                        if (scl_fall && byte_done) begin
                            bitcnt <= '0;
                            if (state == ST_ADDR) begin
                                rd_mode <= shreg[0];
                            end else if (state == ST_SUB) begin
                                ptr    <= shreg[PTR_W-1:0];
                                inc_en <= shreg[4];
                            end else begin
                                if (ptr < PTR_LIMIT) begin
                                    wr_en   <= 1'b1;
                                    wr_idx  <= ptr;
                                    wr_data <= shreg;
                                end
                                if (inc_en) ptr <= ptr + 1'b1;
                            end
                        end
                    end
                    ST_ADDR_ACK: begin
                        if (scl_fall && rd_mode) begin
                            txsh   <= status_byte;
                            bitcnt <= '0;
                        end
                    end
                    ST_TX: begin
                        if (scl_fall) begin
                            if (bitcnt == TX_LAST) begin
                                bitcnt <= '0;
                            end else begin
                                txsh   <= {txsh[6:0], 1'b0};
                                bitcnt <= bitcnt + 4'd1;
                            end
                        end
                    end
                    ST_TX_ACK: begin
                        if (scl_rise) mack <= ~sda_s;
                        if (scl_fall && mack) txsh <= status_byte;
                    end
                    default: ;
                endcase
            end
        end
    end

    // outputs
    always_comb begin
        sda_pull = 1'b0;
        unique case (state)
            ST_ADDR_ACK, ST_SUB_ACK, ST_DATA_ACK: sda_pull = 1'b1;
            ST_TX:                                sda_pull = ~txsh[7];
            default:                              sda_pull = 1'b0;
        endcase
    end

endmodule

// File: rtl/i2c_ctrl_slave_chk.sv
module i2c_ctrl_slave_chk
    import i2c_ctrl_pkg::*;
#(
    parameter int unsigned NREG  = 10,
    parameter int unsigned PTR_W = 4
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic                   scl_in,
    input logic                   sda_pull,
    input logic                   bus_free,
    input logic                   stop_det,
    input cs_state_t              state,
    input logic                   wr_en,
    input logic [PTR_W-1:0]       wr_idx,
    input logic [NREG*BYTE_W-1:0] ctrl_regs
);

    // R11
    sda_edge_scl_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sda_pull) |-> !scl_in);

    // R1
    free_bus_released_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_free |-> !sda_pull);

    // R1
    stop_to_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stop_det |=> state == ST_IDLE);

    // R5
    write_in_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> wr_idx < PTR_W'(NREG));

    // R4
    regs_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(ctrl_regs));

endmodule

bind i2c_ctrl_slave i2c_ctrl_slave_chk #(.NREG(NREG), .PTR_W(PTR_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .scl_in   (scl_in),
    .sda_pull (sda_pull),
    .bus_free (bus_free),
    .stop_det (stop_det),
    .state    (state),
    .wr_en    (wr_en),
    .wr_idx   (wr_idx),
    .ctrl_regs(ctrl_regs)
);

// File: tb/i2c_ctrl_slave_test.sv
module i2c_ctrl_slave_test;

    localparam int    Q      = 50;
    localparam [7:0]  AW0    = 8'h88;
    localparam [7:0]  AR0    = 8'h89;
    localparam [7:0]  AW1    = 8'h8A;
    // {subaddress, data}: single-byte writes
    localparam logic [15:0] VEC [8] = '{
        16'h00A5, 16'hE23C, 16'h0981, 16'h0C77,
        16'h075A, 16'h0FFF, 16'h0412, 16'h08C3
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        m_scl = 1'b1;
    logic        m_sda = 1'b1;
    logic        addr_sel = 1'b0;
    logic        st_p = 1'b1, st_z = 1'b0, st_s = 1'b0, st_t = 1'b0;
    logic        sda_pull;
    logic [79:0] ctrl_regs;
    logic        sda_line;
    logic [79:0] exp_regs = '0;
    int          errs = 0;
    int          nchk = 0;
    int          r11_bad = 0;

    always #5 clk = ~clk;
    assign sda_line = m_sda & ~sda_pull;

    i2c_ctrl_slave uut (
        .clk(clk), .rst_n(rst_n), .scl_in(m_scl), .sda_in(sda_line),
        .addr_sel(addr_sel), .stat_pause_n(st_p), .stat_zc_mute(st_z),
        .stat_soft_mute(st_s), .stat_stereo(st_t),
        .sda_pull(sda_pull), .ctrl_regs(ctrl_regs)
    );

    always @(sda_pull) if (rst_n && m_scl) r11_bad++;

    task automatic chk(input bit ok, input string tag, input logic [79:0] act, input logic [79:0] exp);
        nchk++;
        if (!ok) begin
            errs++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic t_start();
        m_sda = 1'b1; #Q;
        m_scl = 1'b1; #Q;
        m_sda = 1'b0; #Q;
        m_scl = 1'b0; #Q;
    endtask

    task automatic t_stop();
        m_sda = 1'b0; #Q;
        m_scl = 1'b1; #Q;
        m_sda = 1'b1; #Q;
    endtask

    task automatic wbyte(input logic [7:0] b, output bit ack);
        for (int i = 7; i >= 0; i--) begin
            m_sda = b[i]; #Q;
            m_scl = 1'b1; #(2*Q);
            m_scl = 1'b0; #Q;
        end
        m_sda = 1'b1; #Q;
        m_scl = 1'b1; #Q;
        ack = !sda_line; #Q;
        m_scl = 1'b0; #Q;
    endtask

    task automatic rbyte(input bit give_ack, output logic [7:0] b);
        m_sda = 1'b1;
        for (int i = 7; i >= 0; i--) begin
            #Q; m_scl = 1'b1;
            #Q; b[i] = sda_line;
            #Q; m_scl = 1'b0;
            #Q;
        end
        m_sda = give_ack ? 1'b0 : 1'b1; #Q;
        m_scl = 1'b1; #(2*Q);
        m_scl = 1'b0; #Q;
        m_sda = 1'b1;
    endtask

    task automatic wr_single(input logic [7:0] adr, input logic [7:0] sub, input logic [7:0] dat, output bit all_ack);
        bit a1, a2, a3;
        t_start();
        wbyte(adr, a1);
        wbyte(sub, a2);
        wbyte(dat, a3);
        t_stop();
        all_ack = a1 && a2 && a3;
    endtask

    initial begin
        #(150000 * 10);
        errs++; nchk++;
        $display("FAIL watchdog expired actual=1 expected=0");
        $display("Result: errors=%0d of %0d checks", errs, nchk);
        $finish;
    end

    initial begin
        bit ok, a;
        logic [7:0] rd;
        #103;
        // R10: reset state
        chk(ctrl_regs == '0, "R10 regs after reset", ctrl_regs, '0);
        chk(sda_pull == 1'b0, "R10 sda released in reset", 80'(sda_pull), 80'(0));
        rst_n = 1'b1;
        #(4*Q);

        // table of single-byte writes: R4, R5 (dropped indices 12 and 15)
        for (int k = 0; k < 8; k++) begin
            int idx;
            idx = int'(VEC[k][11:8]);
            wr_single(AW0, VEC[k][15:8], VEC[k][7:0], ok);
            chk(ok, "R4 acks on write", 80'(ok), 80'(1));
            if (idx < 10) exp_regs[idx*8 +: 8] = VEC[k][7:0];
            chk(ctrl_regs == exp_regs, idx < 10 ? "R4 register write" : "R5 dropped index", ctrl_regs, exp_regs);
        end
        // R3: subaddress 0xE2 landed on register 2 despite bits 7:5 set
        chk(ctrl_regs[23:16] == 8'h3C, "R3 upper subaddress bits ignored", 80'(ctrl_regs[23:16]), 80'(8'h3C));

        // R2: address mismatch -> no ack, bus ignored until STOP
        t_start();
        wbyte(AW1, a);
        chk(!a, "R2 mismatch not acked", 80'(a), 80'(0));
        wbyte(8'h00, a);
        wbyte(8'hEE, a);
        t_stop();
        chk(ctrl_regs == exp_regs, "R2 mismatch writes nothing", ctrl_regs, exp_regs);

        // R2 / R1: select pin changes the address; new START after STOP accepted
        addr_sel = 1'b1;
        wr_single(AW1, 8'h01, 8'h5E, ok);
        exp_regs[15:8] = 8'h5E;
        chk(ok, "R1 R2 address with select pin acked", 80'(ok), 80'(1));
        chk(ctrl_regs == exp_regs, "R2 write via selected address", ctrl_regs, exp_regs);
        addr_sel = 1'b0;

        // R5: auto-increment over the four speaker registers
        t_start();
        wbyte(AW0, a);
        wbyte(8'h14, a);
        for (int k = 0; k < 4; k++) begin
            wbyte(8'h41 + 8'(k), a);
            exp_regs[(4+k)*8 +: 8] = 8'h41 + 8'(k);
        end
        t_stop();
        chk(ctrl_regs == exp_regs, "R5 auto-increment run", ctrl_regs, exp_regs);

        // R5: modulo-16 walk from 8, dropping 10..15, wrapping to 0..3
        t_start();
        wbyte(AW0, a);
        wbyte(8'h18, a);
        ok = 1'b1;
        for (int k = 0; k < 12; k++) begin
            int p;
            wbyte(8'hB0 + 8'(k), a);
            ok = ok && a;
            p = (8 + k) % 16;
            if (p < 10) exp_regs[p*8 +: 8] = 8'hB0 + 8'(k);
        end
        t_stop();
        chk(ok, "R5 dropped bytes still acked", 80'(ok), 80'(1));
        chk(ctrl_regs == exp_regs, "R5 modulo-16 wrap", ctrl_regs, exp_regs);

        // R6: no increment, stream into register 6
        t_start();
        wbyte(AW0, a);
        wbyte(8'h06, a);
        wbyte(8'h61, a);
        wbyte(8'h62, a);
        wbyte(8'h63, a);
        t_stop();
        exp_regs[55:48] = 8'h63;
        chk(ctrl_regs == exp_regs, "R6 repeated writes one register", ctrl_regs, exp_regs);

        // R7: START inside an open transfer is taken as data bits
        t_start();
        wbyte(AW0, a);
        wbyte(8'h03, a);
        wbyte(8'h11, a);
        t_start();
        wbyte(AR0, a);
        t_stop();
        exp_regs[31:24] = 8'hC4;
        chk(ctrl_regs == exp_regs, "R7 unrecognised START shifted as data", ctrl_regs, exp_regs);

        // R8 / R9: read status twice with a change in between
        st_p = 1'b1; st_z = 1'b0; st_s = 1'b1; st_t = 1'b0;
        t_start();
        wbyte(AR0, a);
        chk(a, "R8 read address acked", 80'(a), 80'(1));
        fork
            rbyte(1'b1, rd);
            begin
                #(Q*4*5);
                st_p = 1'b0; st_z = 1'b1; st_s = 1'b0; st_t = 1'b1;
            end
        join
        chk(rd == 8'h05, "R8 status byte layout", 80'(rd), 80'(8'h05));
        rbyte(1'b0, rd);
        chk(rd == 8'h0A, "R9 status resampled after ACK", 80'(rd), 80'(8'h0A));
        chk(sda_pull == 1'b0, "R9 SDA released after NACK", 80'(sda_pull), 80'(0));
        t_stop();
        chk(ctrl_regs == exp_regs, "R9 read leaves registers", ctrl_regs, exp_regs);

        // R1: fresh transfer after the read
        wr_single(AW0, 8'h09, 8'h3D, ok);
        exp_regs[79:72] = 8'h3D;
        chk(ok && ctrl_regs == exp_regs, "R1 transfer after STOP", ctrl_regs, exp_regs);

        // R11: SDA only moved while SCL low
        chk(r11_bad == 0, "R11 sda change with SCL high", 80'(r11_bad), 80'(0));

        $display("Result: errors=%0d of %0d checks", errs, nchk);
        $finish;
    end

endmodule